// File: doc/BRIEF.md
# Robbed-Bit Signaling Supervisor

This block watches a system-timed T1 serial stream, one bit per accepted beat, together with a frame marker and a multiframe marker. It recovers the per-channel robbed-bit signaling from the least significant bit of each channel in the signaling frames. At each multiframe boundary it decides whether the recovered ABCD values may move to the outputs. It then replays the committed values on four outputs during every channel's time slot, in every frame.

Updates can be suspended. A slip indication suspends them for one multiframe. An active-low hold input suspends them for as long as it stays low. A flag shows that the outputs are frozen. A selectable per-channel integration filter requires several matching multiframes before a new value is accepted. The filter's depth is cut back to two matching multiframes for the first update that follows a freeze.

The stream side carries `in_valid` but no ready. The stream is clock-recovered and cannot be stalled, so the block never applies back-pressure. Beats with `in_valid` low carry nothing and advance no position. `sig_vld` marks the cycles in which the outputs belong to a channel slot.

Top module: `rbs_supervisor`

## Requirements
- R1: A is the last bit (LSB, eighth bit after the frame bit) of each channel in frame 6, and B is the same bit in frame 12. Frames are counted from 1 at the beat carrying `mf_start`. The outputs are ordered {sig_a, sig_b, sig_c, sig_d}.
- R2: With `esf_mode`=1, C is the channel LSB of frame 18 and D is the channel LSB of frame 24.
- R3: With `esf_mode`=0, the C and D values committed at a boundary are the A and B values captured in the multiframe before the one just completed.
- R4: One cycle after each accepted payload beat, `sig_vld` is 1 and the outputs show the committed ABCD of that beat's channel. This holds in every frame of the multiframe.
- R5: Committed values change only on the clock edge of an accepted beat with `mf_start`=1.
- R6: While `hold_n` is 0, no boundary updates the committed values.
- R7: A `slip` pulse blocks the next boundary. The boundary after that may update again.
- R8: `sig_frz` is 1 from the cycle after `hold_n` is low or `slip` is high. It returns to 0 after the first boundary that is allowed to update. It is 0 after reset.
- R9: `sup_mode` 01, 10 and 11 commit a channel's new sample only once 2, 3 or 4 consecutive multiframe samples (counting the current one) are equal.
- R10: At the first allowed boundary after a freeze (`sig_frz` high going in), the required match count is at most 2.
- R11: `sup_mode` 00 commits each new sample directly.
- R12: Beats with `in_valid`=0 are ignored and leave `sig_vld`=0. Beats carrying a frame marker also leave `sig_vld`=0.
- R13: After reset, all committed values and outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies the beat on in_bit and the markers |
| in_bit | input | 1 | Serial PCM bit |
| frame_start | input | 1 | Beat is the frame bit of a frame |
| mf_start | input | 1 | Beat is the frame bit of frame 1 (multiframe boundary) |
| esf_mode | input | 1 | 1: 24-frame ABCD framing, 0: 12-frame AB framing |
| sup_mode | input | 2 | Integration depth: 00 bypass, 01 two, 10 three, 11 four |
| hold_n | input | 1 | Active-low freeze request |
| slip | input | 1 | Slip indication, one-cycle pulse |
| sig_vld | output | 1 | Outputs belong to the channel of the previous beat |
| sig_a | output | 1 | Signaling bit A |
| sig_b | output | 1 | Signaling bit B |
| sig_c | output | 1 | Signaling bit C |
| sig_d | output | 1 | Signaling bit D |
| sig_frz | output | 1 | Signaling updates frozen |

## Verification
A slot timer that drifts by one bit samples the wrong LSB. This shows at the ports one boundary later, as a wrong ABCD on every channel slot of the next multiframe. Wrong freeze bookkeeping shows within the same multiframe through `sig_frz`. It also shows at the next boundary, as an update that occurs or fails to occur. A wrong match counter appears only after the two to four multiframes the filter needs. The bench therefore keeps each mode active for ten multiframes and compares every payload beat against its own model.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  localparam int FRAME_A    = 6;
  localparam int FRAME_B    = 12;
  localparam int FRAME_C    = 18;
  localparam int FRAME_D    = 24;
  localparam int MAX_FRAMES = 24;
  localparam int MAX_NEED   = 4;
  localparam int CNT_W      = $clog2(MAX_NEED + 1);

  typedef logic [3:0] abcd_t;

  // Required run length of equal samples; 0 means bypass.
  function automatic logic [CNT_W-1:0] need_of(input logic [1:0] mode, input logic capped);
    logic [CNT_W-1:0] n;
    case (mode)
      2'b00:   n = '0;
      2'b01:   n = CNT_W'(2);
      2'b10:   n = CNT_W'(3);
      default: n = CNT_W'(4);
    endcase
    if (capped && n > CNT_W'(2)) n = CNT_W'(2);
    return n;
  endfunction
endpackage

// File: rtl/rbs_slot_timer.sv
module rbs_slot_timer #(
  parameter int NUM_CH      = 24,
  parameter int BITS_PER_CH = 8,
  parameter int CHW         = 5,
  parameter int FRW         = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           frame_start,
  input  logic           mf_start,
  output logic           cur_pay,
  output logic [CHW-1:0] cur_ch,
  output logic           cur_lsb,
  output logic [FRW-1:0] cur_frame,
  output logic           boundary
);
  localparam int BPW = (BITS_PER_CH > 1) ? $clog2(BITS_PER_CH) : 1;

  logic [FRW-1:0] frame_r, nxt_frame;
  logic [CHW-1:0] ch_r, nxt_ch;
  logic [BPW-1:0] bp_r, nxt_bp;
  logic           pay_r, nxt_pay, was_f;

  // Position of the beat presented this cycle
  always_comb begin
    nxt_frame = frame_r;
    nxt_ch    = ch_r;
    nxt_bp    = bp_r;
    nxt_pay   = 1'b0;
    if (mf_start)         nxt_frame = FRW'(1);
    else if (frame_start) nxt_frame = frame_r + 1'b1;
    if (frame_start || mf_start) begin
      nxt_ch  = '0;
      nxt_bp  = '0;
      nxt_pay = 1'b0;
    end else if (was_f) begin
      nxt_ch  = '0;
      nxt_bp  = '0;
      nxt_pay = 1'b1;
    end else if (pay_r) begin
      if (bp_r == BPW'(BITS_PER_CH - 1)) begin
        nxt_bp  = '0;
        nxt_ch  = ch_r + 1'b1;
        nxt_pay = (int'(ch_r) < NUM_CH - 1);
      end else begin
        nxt_bp  = bp_r + 1'b1;
        nxt_pay = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_r <= '0;
      ch_r    <= '0;
      bp_r    <= '0;
      pay_r   <= 1'b0;
      was_f   <= 1'b0;
    end else if (in_valid) begin
      frame_r <= nxt_frame;
      ch_r    <= nxt_ch;
      bp_r    <= nxt_bp;
      pay_r   <= nxt_pay;
      was_f   <= frame_start || mf_start;
    end
  end

  assign cur_pay   = in_valid && nxt_pay;
  assign cur_ch    = nxt_ch;
  assign cur_lsb   = (nxt_bp == BPW'(BITS_PER_CH - 1));
  assign cur_frame = nxt_frame;
  assign boundary  = in_valid && mf_start;
endmodule

// File: rtl/rbs_sig_capture.sv
module rbs_sig_capture import rbs_pkg::*; #(
  parameter int NUM_CH = 24,
  parameter int CHW    = 5,
  parameter int FRW    = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cap_pay,
  input  logic                  cap_lsb,
  input  logic [CHW-1:0]        cap_ch,
  input  logic [FRW-1:0]        cap_frame,
  input  logic                  in_bit,
  input  logic                  esf,
  input  logic                  boundary,
  output logic [NUM_CH-1:0][3:0] sample
);
  logic take;
  assign take = cap_pay && cap_lsb;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic ra, rb, rc, rd, hit;
    assign hit = take && (cap_ch == CHW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ra <= 1'b0;
        rb <= 1'b0;
        rc <= 1'b0;
        rd <= 1'b0;
      end else begin
        if (hit && cap_frame == FRW'(FRAME_A))        ra <= in_bit;
        if (hit && cap_frame == FRW'(FRAME_B))        rb <= in_bit;
        if (hit && esf && cap_frame == FRW'(FRAME_C)) rc <= in_bit;
        if (hit && esf && cap_frame == FRW'(FRAME_D)) rd <= in_bit;
        // 12-frame framing: C/D carry the A/B of the multiframe before
        if (boundary && !esf) begin
          rc <= ra;
          rd <= rb;
        end
      end
    end

    assign sample[i] = {ra, rb, rc, rd};
  end
endmodule

// File: rtl/rbs_integrator.sv
module rbs_integrator import rbs_pkg::*; #(
  parameter int NUM_CH = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   boundary,
  input  logic                   allow,
  input  logic [CNT_W-1:0]       need,
  input  logic [NUM_CH-1:0][3:0] sample,
  output logic [NUM_CH-1:0][3:0] commit
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    abcd_t            cand, com;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             mature;

    always_comb begin
      if (sample[i] == cand)
        cnt_n = (cnt == CNT_W'(MAX_NEED)) ? cnt : cnt + 1'b1;
      else
        cnt_n = CNT_W'(1);
      mature = (need == '0) || (cnt_n >= need);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cand <= '0;
        cnt  <= '0;
        com  <= '0;
      end else if (boundary) begin
        cand <= sample[i];
        cnt  <= cnt_n;
        if (allow && mature) com <= sample[i];
      end
    end

    assign commit[i] = com;
  end
endmodule

// File: rtl/rbs_freeze.sv
module rbs_freeze (
  input  logic clk,
  input  logic rst_n,
  input  logic boundary,
  input  logic hold_n,
  input  logic slip,
  output logic allow,
  output logic frz,
  output logic capped
);
  logic armed;

  assign allow  = boundary && hold_n && !armed && !slip;
  assign capped = frz;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      frz   <= 1'b0;
    end else begin
      if (slip)          armed <= 1'b1;
      else if (boundary) armed <= 1'b0;
      if (!hold_n || slip) frz <= 1'b1;
      else if (allow)      frz <= 1'b0;
    end
  end
endmodule

// File: rtl/rbs_supervisor.sv
module rbs_supervisor import rbs_pkg::*; #(
  parameter int NUM_CH      = 24,
  parameter int BITS_PER_CH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_bit,
  input  logic       frame_start,
  input  logic       mf_start,
  input  logic       esf_mode,
  input  logic [1:0] sup_mode,
  input  logic       hold_n,
  input  logic       slip,
  output logic       sig_vld,
  output logic       sig_a,
  output logic       sig_b,
  output logic       sig_c,
  output logic       sig_d,
  output logic       sig_frz
);
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int FRW = $clog2(MAX_FRAMES + 1);

  logic                   cur_pay, cur_lsb, boundary, allow, capped;
  logic [CHW-1:0]         cur_ch;
  logic [FRW-1:0]         cur_frame;
  logic [NUM_CH-1:0][3:0] sample_bus, commit_bus;
  logic [CNT_W-1:0]       need;
  abcd_t                  sig_q;

  rbs_slot_timer #(.NUM_CH(NUM_CH), .BITS_PER_CH(BITS_PER_CH), .CHW(CHW), .FRW(FRW)) u_timer (
    .clk, .rst_n, .in_valid, .frame_start, .mf_start,
    .cur_pay, .cur_ch, .cur_lsb, .cur_frame, .boundary
  );

  rbs_sig_capture #(.NUM_CH(NUM_CH), .CHW(CHW), .FRW(FRW)) u_capture (
    .clk, .rst_n, .cap_pay(cur_pay), .cap_lsb(cur_lsb), .cap_ch(cur_ch),
    .cap_frame(cur_frame), .in_bit, .esf(esf_mode), .boundary, .sample(sample_bus)
  );

  rbs_freeze u_freeze (
    .clk, .rst_n, .boundary, .hold_n, .slip, .allow, .frz(sig_frz), .capped
  );

  assign need = need_of(sup_mode, capped);

  rbs_integrator #(.NUM_CH(NUM_CH)) u_integ (
    .clk, .rst_n, .boundary, .allow, .need, .sample(sample_bus), .commit(commit_bus)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sig_vld <= 1'b0;
      sig_q   <= '0;
    end else begin
      sig_vld <= cur_pay;
      if (cur_pay) sig_q <= commit_bus[cur_ch];
    end
  end

  assign {sig_a, sig_b, sig_c, sig_d} = sig_q;
endmodule

// File: rtl/rbs_supervisor_chk.sv
module rbs_supervisor_chk #(
  parameter int NUM_CH = 24
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  mf_start,
  input logic                  hold_n,
  input logic                  sig_vld,
  input logic                  sig_frz,
  input logic [NUM_CH*4-1:0]   commit_bus
);
  // R5
  commit_only_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && mf_start) |=> $stable(commit_bus));

  // R6
  hold_blocks_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mf_start && !hold_n) |=> $stable(commit_bus));

  // R8
  hold_raises_frz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |=> sig_frz);

  // R8
  frz_clears_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sig_frz) |-> $past(in_valid && mf_start));

  // R12
  idle_no_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !sig_vld);
endmodule

bind rbs_supervisor rbs_supervisor_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mf_start(mf_start),
  .hold_n(hold_n), .sig_vld(sig_vld), .sig_frz(sig_frz), .commit_bus(commit_bus)
);

// File: tb/rbs_supervisor_tb.sv
module rbs_supervisor_tb;
  localparam int NCH = 4;
  localparam int BPC = 8;
  localparam int NMF = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_bit = 0, frame_start = 0, mf_start = 0;
  logic esf_mode = 1, hold_n = 1, slip = 0;
  logic [1:0] sup_mode = 2'b00;
  logic sig_vld, sig_a, sig_b, sig_c, sig_d, sig_frz;

  always #4 clk = ~clk;

  rbs_supervisor #(.NUM_CH(NCH), .BITS_PER_CH(BPC)) u_dut (
    .clk, .rst_n, .in_valid, .in_bit, .frame_start, .mf_start, .esf_mode,
    .sup_mode, .hold_n, .slip, .sig_vld, .sig_a, .sig_b, .sig_c, .sig_d, .sig_frz
  );

  int n_run = 0, n_fail = 0, gap = 0;
  logic [3:0] m_com [NCH], m_cand [NCH];
  int         m_cnt [NCH];
  logic       ma [NCH], mb [NCH], mc [NCH], md [NCH];
  logic       m_frz = 0, m_arm = 0, slip_req = 0;
  string      mf_tag = "R13";

  task automatic check(input bit ok, input string req, input int got, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic int need_for(input logic [1:0] md_sel, input logic capf);
    int n;
    n = (md_sel == 2'b00) ? 0 : int'(md_sel) + 1;
    if (capf && n > 2) n = 2;
    return n;
  endfunction

  function automatic logic [3:0] sigval(input int k, input int c);
    logic [3:0] v;
    v = 4'(((k / 3) * 5 + c * 3 + 1) & 15);
    if ((k + c) % 7 == 3) v = v ^ (4'b1000 >> (c % 4));
    return v;
  endfunction

  task automatic model_boundary(input logic alw, input logic capf);
    logic [3:0] s;
    int need;
    need = need_for(sup_mode, capf);
    for (int c = 0; c < NCH; c++) begin
      s = {ma[c], mb[c], mc[c], md[c]};
      if (s == m_cand[c]) m_cnt[c] = (m_cnt[c] >= 4) ? 4 : m_cnt[c] + 1;
      else m_cnt[c] = 1;
      m_cand[c] = s;
      if (alw && (need == 0 || m_cnt[c] >= need)) m_com[c] = s;
      if (!esf_mode) begin
        mc[c] = ma[c];
        md[c] = mb[c];
      end
    end
    if (!alw) mf_tag = !hold_n ? "R6" : "R7";
    else if (capf) mf_tag = "R10";
    else if (sup_mode == 2'b00) mf_tag = "R11";
    else mf_tag = "R9";
    mf_tag = {mf_tag, esf_mode ? " R2" : " R3"};
  endtask

  task automatic beat(input logic v, input logic fs, input logic ms, input logic b,
                      input logic exp_pay, input int ch);
    logic bnd, blk, alw, capf;
    @(negedge clk);
    in_valid = v; frame_start = fs; mf_start = ms; in_bit = b; slip = slip_req;
    bnd  = v && ms;
    blk  = !hold_n || m_arm || slip_req;
    alw  = bnd && !blk;
    capf = m_frz;
    if (bnd) model_boundary(alw, capf);
    m_frz = (!hold_n || slip_req) ? 1'b1 : (alw ? 1'b0 : m_frz);
    m_arm = slip_req ? 1'b1 : (bnd ? 1'b0 : m_arm);
    @(posedge clk);
    #2;
    slip_req = 0;
    check(sig_frz == m_frz, "R8 freeze flag", sig_frz, m_frz);
    if (!v) check(sig_vld == 1'b0, "R12 idle beat", sig_vld, 0);
    else    check(sig_vld == exp_pay, "R4 R12 slot valid", sig_vld, exp_pay);
    if (v && exp_pay)
      check({sig_a, sig_b, sig_c, sig_d} == m_com[ch],
            $sformatf("R1 R4 R5 %s ch%0d", mf_tag, ch),
            {sig_a, sig_b, sig_c, sig_d}, m_com[ch]);
  endtask

  task automatic maybe_idle();
    gap++;
    if (gap % 5 == 0) beat(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 0);
  endtask

  task automatic send_mf(input int k);
    int nf;
    logic [3:0] v;
    logic b;
    nf = esf_mode ? 24 : 12;
    for (int f = 1; f <= nf; f++) begin
      maybe_idle();
      beat(1'b1, 1'b1, f == 1, 1'b0, 1'b0, 0);
      for (int c = 0; c < NCH; c++) begin
        v = sigval(k, c);
        for (int bp = 0; bp < BPC; bp++) begin
          b = 1'((c ^ bp ^ f) & 1);
          if (bp == BPC - 1) begin
            if (f == 6)  begin b = v[3]; ma[c] = b; end
            if (f == 12) begin b = v[2]; mb[c] = b; end
            if (f == 18 && esf_mode) begin b = v[1]; mc[c] = b; end
            if (f == 24 && esf_mode) begin b = v[0]; md[c] = b; end
          end
          if ((k == 4 || k == 17 || k == 33 || k == 55) && f == 9 && c == 0 && bp == 0)
            slip_req = 1;
          maybe_idle();
          beat(1'b1, 1'b0, 1'b0, b, 1'b1, c);
        end
      end
    end
  endtask

  initial begin
    #1_400_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_com[c] = '0; m_cand[c] = '0; m_cnt[c] = 0;
      ma[c] = 0; mb[c] = 0; mc[c] = 0; md[c] = 0;
    end
    repeat (4) @(posedge clk);
    #2;
    // R13 reset state
    check({sig_vld, sig_a, sig_b, sig_c, sig_d} == 5'b0, "R13 reset outputs",
          {sig_vld, sig_a, sig_b, sig_c, sig_d}, 0);
    check(sig_frz == 1'b0, "R13 R8 reset freeze", sig_frz, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NMF; k++) begin
      esf_mode = !(k >= 40 && k < 52);
      sup_mode = 2'((k / 10) % 4);
      hold_n   = !(k == 8 || k == 23 || k == 24 || k == 45);
      send_mf(k);
    end
    esf_mode = 1; hold_n = 1;
    beat(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 0);
    for (int c = 0; c < NCH; c++)
      for (int bp = 0; bp < BPC; bp++) beat(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, c);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule